// File: doc/BRIEF.md
# Combinational Restoring-Array Divider

This block divides an unsigned 8-bit dividend by an unsigned 4-bit divisor with no clock at all. It produces a 4-bit quotient and a 4-bit remainder in the same evaluation. The datapath is a stack of identical rows, one row for each quotient bit. Each row is a carry chain of conditional-subtractor cells. A row appends the next dividend bit to the partial remainder from the row above and tries to subtract the divisor. The final carry of the chain becomes that row's quotient bit. The same bit then tells every cell in the row whether to pass its remainder bit through or to emit the difference bit.

A separate flag reports when the true quotient cannot fit in four bits. This happens when the upper dividend nibble is equal to or larger than the divisor, and it includes a zero divisor. While the flag is set, the quotient and remainder outputs carry no defined meaning. The block sits between registers owned by the surrounding logic, so its inputs and outputs are plain data with no handshake.

Top module: `array_divider`

## Requirements
- R1: When overflow_o is 0, quotient_o equals floor(dividend_i / divisor_i).
- R2: When overflow_o is 0, remainder_o equals dividend_i modulo divisor_i.
- R3: overflow_o is 1 exactly when dividend_i[7:4] is greater than or equal to divisor_i.
- R4: A divisor of zero always gives overflow_o = 1, whatever the dividend.
- R5: When overflow_o is 0, remainder_o is strictly less than divisor_i.
- R6: When overflow_o is 0, quotient_o * divisor_i + remainder_o reproduces dividend_i exactly.
- R7: A divisor of 1 with dividend_i[7:4] = 0 gives quotient_o = dividend_i[3:0] and remainder_o = 0.
- R8: When dividend_i is below divisor_i, every row passes its remainder bits through unchanged, so quotient_o = 0 and remainder_o = dividend_i[3:0].
- R9: The outputs depend only on the present inputs; applying the same operands again gives the same results, whatever was applied before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dividend_i | input | 8 | Unsigned dividend |
| divisor_i | input | 4 | Unsigned divisor |
| quotient_o | output | 4 | Quotient, bit 3 decided by the top row |
| remainder_o | output | 4 | Remainder from the bottom row |
| overflow_o | output | 1 | Quotient does not fit, or the divisor is zero |

## Verification
Every result is due in the same cycle that its operands are applied, because no register lies between any input and any output. The bench changes the operands just after a rising clock edge. It then reads the outputs one nanosecond later, well before the falling edge, so the carry chains have settled. The bench never waits on an edge to see a result. For R9, it applies one pair of operands again after many unrelated pairs, and the outputs must match the first results.

// File: rtl/array_divider_pkg.sv
package array_divider_pkg;
  // Default operand widths; the quotient width follows from them.
  localparam int unsigned DIVIDEND_W_DEF = 8;
  localparam int unsigned DIVISOR_W_DEF  = 4;

  // Carry of a subtract chain: 1 means the minuend was not smaller.
  typedef enum logic {
    BORROW_TAKEN = 1'b0,
    FITS         = 1'b1
  } row_fit_e;
endpackage

// File: rtl/cond_sub_cell.sv
// One bit of a conditional subtractor. The carry is always the subtract
// carry; the sum is either the remainder bit or the difference bit.
module cond_sub_cell (
  input  logic rbit_i,   // partial remainder bit
  input  logic dinv_i,   // complemented divisor bit
  input  logic cin_i,    // carry from the less significant cell
  input  logic sel_i,    // row decision: 1 = take difference
  output logic sum_o,
  output logic cout_o
);
  logic diff_bit;

  assign diff_bit = rbit_i ^ dinv_i ^ cin_i;
  assign cout_o   = (rbit_i & dinv_i) | (rbit_i & cin_i) | (dinv_i & cin_i);
  assign sum_o    = sel_i ? diff_bit : rbit_i;
endmodule

// File: rtl/div_row.sv
// One row of the array: W+1 cells subtract a zero-extended divisor from
// the shifted partial remainder and keep or discard the difference.
module div_row #(
  parameter int unsigned W = 4
) (
  input  logic [W:0]   part_i,  // shifted partial remainder
  input  logic [W-1:0] dvs_i,   // divisor
  output logic         qbit_o,  // 1 when part_i >= divisor
  output logic [W:0]   rem_o    // next partial remainder
);
  import array_divider_pkg::*;

  localparam int unsigned CELLS = W + 1;

  logic [CELLS-1:0] dinv;
  logic [CELLS:0]   carry;
  row_fit_e         fit;

  assign dinv     = ~{1'b0, dvs_i};
  assign carry[0] = 1'b1;  // +1 of the two's-complement subtraction

  for (genvar b = 0; b < CELLS; b++) begin : g_cell
    cond_sub_cell u_cell (
      .rbit_i (part_i[b]),
      .dinv_i (dinv[b]),
      .cin_i  (carry[b]),
      .sel_i  (qbit_o),
      .sum_o  (rem_o[b]),
      .cout_o (carry[b+1])
    );
  end

  assign fit    = row_fit_e'(carry[CELLS]);
  assign qbit_o = (fit == FITS);
endmodule

// File: rtl/array_divider.sv
module array_divider #(
  parameter int unsigned DIVIDEND_W = array_divider_pkg::DIVIDEND_W_DEF,
  parameter int unsigned DIVISOR_W  = array_divider_pkg::DIVISOR_W_DEF
) (
  input  logic [DIVIDEND_W-1:0]           dividend_i,
  input  logic [DIVISOR_W-1:0]            divisor_i,
  output logic [DIVIDEND_W-DIVISOR_W-1:0] quotient_o,
  output logic [DIVISOR_W-1:0]            remainder_o,
  output logic                            overflow_o
);
  localparam int unsigned QW = DIVIDEND_W - DIVISOR_W;

  // Partial remainder entering each row; stage 0 is the upper dividend part.
  logic [DIVISOR_W-1:0] prem [QW+1];
  logic [QW-1:0]        unused_top;
  logic [DIVISOR_W:0]   unused_ovf_rem;

  assign prem[0] = dividend_i[DIVIDEND_W-1 -: DIVISOR_W];

  for (genvar i = 0; i < QW; i++) begin : g_row
    logic [DIVISOR_W:0] part;
    logic [DIVISOR_W:0] next;

    assign part = {prem[i], dividend_i[QW-1-i]};

    div_row #(.W(DIVISOR_W)) u_row (
      .part_i (part),
      .dvs_i  (divisor_i),
      .qbit_o (quotient_o[QW-1-i]),
      .rem_o  (next)
    );

    assign prem[i+1]     = next[DIVISOR_W-1:0];
    assign unused_top[i] = next[DIVISOR_W];
  end

  assign remainder_o = prem[QW];

  // Overflow probe: the same row structure compares the upper dividend
  // part against the divisor; its carry is the ">=" result.
  div_row #(.W(DIVISOR_W)) u_ovf_probe (
    .part_i ({1'b0, prem[0]}),
    .dvs_i  (divisor_i),
    .qbit_o (overflow_o),
    .rem_o  (unused_ovf_rem)
  );
endmodule

// File: rtl/array_divider_chk.sv
module array_divider_chk #(
  parameter int unsigned DIVIDEND_W = 8,
  parameter int unsigned DIVISOR_W  = 4
) (
  input logic [DIVIDEND_W-1:0]           dividend_i,
  input logic [DIVISOR_W-1:0]            divisor_i,
  input logic [DIVIDEND_W-DIVISOR_W-1:0] quotient_o,
  input logic [DIVISOR_W-1:0]            remainder_o,
  input logic                            overflow_o
);
  localparam int unsigned QW = DIVIDEND_W - DIVISOR_W;

  logic [DIVIDEND_W+DIVISOR_W:0] rebuilt;
  logic [DIVISOR_W-1:0]          hi_part;

  always_comb begin
    rebuilt = DIVIDEND_W'(0) + (DIVIDEND_W+DIVISOR_W+1)'(quotient_o) * divisor_i
              + remainder_o;
    hi_part = dividend_i[DIVIDEND_W-1 -: DIVISOR_W];
    if (!$isunknown({dividend_i, divisor_i})) begin
      // R6
      recombine_chk: assert (overflow_o || rebuilt == (DIVIDEND_W+DIVISOR_W+1)'(dividend_i));
      // R5
      rem_below_divisor_chk: assert (overflow_o || remainder_o < divisor_i);
      // R3
      ovf_compare_chk: assert (overflow_o == (hi_part >= divisor_i));
      // R4
      zero_divisor_chk: assert (divisor_i != '0 || overflow_o);
      // R8
      pass_through_chk: assert (dividend_i >= DIVIDEND_W'(divisor_i) ||
                                (quotient_o == QW'(0) &&
                                 remainder_o == dividend_i[DIVISOR_W-1:0]));
    end
  end
endmodule

bind array_divider array_divider_chk #(
  .DIVIDEND_W (DIVIDEND_W),
  .DIVISOR_W  (DIVISOR_W)
) u_chk (
  .dividend_i  (dividend_i),
  .divisor_i   (divisor_i),
  .quotient_o  (quotient_o),
  .remainder_o (remainder_o),
  .overflow_o  (overflow_o)
);

// File: tb/array_divider_test.sv
module array_divider_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] dividend;
  logic [3:0] divisor;
  logic [3:0] quotient;
  logic [3:0] remainder;
  logic       overflow;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  array_divider uut (
    .dividend_i  (dividend),
    .divisor_i   (divisor),
    .quotient_o  (quotient),
    .remainder_o (remainder),
    .overflow_o  (overflow)
  );

  function automatic logic exp_ovf(input logic [7:0] a, input logic [3:0] b);
    return a[7:4] >= b;
  endfunction

  function automatic logic [3:0] exp_quo(input logic [7:0] a, input logic [3:0] b);
    int unsigned t = a / b;
    return t[3:0];
  endfunction

  function automatic logic [3:0] exp_rem(input logic [7:0] a, input logic [3:0] b);
    int unsigned t = a % b;
    return t[3:0];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (dividend %0d divisor %0d)",
               req, act, exp, dividend, divisor);
    end
  endtask

  // Apply operands just after a rising edge, read 1 ns later.
  task automatic apply(input logic [7:0] a, input logic [3:0] b);
    @(posedge clk);
    dividend = a;
    divisor  = b;
    #1;
  endtask

  task automatic full_check(input logic [7:0] a, input logic [3:0] b);
    apply(a, b);
    check("R3 overflow", int'(overflow), int'(exp_ovf(a, b)));
    if (b == 4'd0) check("R4 zero divisor", int'(overflow), 1);
    if (!exp_ovf(a, b)) begin
      check("R1 quotient", int'(quotient), int'(exp_quo(a, b)));
      check("R2 remainder", int'(remainder), int'(exp_rem(a, b)));
      check("R5 rem<divisor", int'(remainder < b), 1);
      check("R6 recombine", int'(quotient) * int'(b) + int'(remainder), int'(a));
    end
  endtask

  initial begin
    #(5ns * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] q_first, r_first;
    void'($urandom(32'h5eed_d1f7));
    dividend = 8'd0;
    divisor  = 4'd0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // Idle operands 0/0: zero divisor must flag overflow (R4)
    check("R4 idle zero divisor", int'(overflow), 1);

    // Directed corners
    full_check(8'd0, 4'd0);
    full_check(8'hFF, 4'd0);
    full_check(8'hFF, 4'hF);
    full_check(8'hEF, 4'hF);     // largest non-overflow with divisor 15
    full_check(8'h7F, 4'd8);
    full_check(8'h80, 4'd8);     // boundary: hi == divisor
    full_check(8'd100, 4'd7);
    full_check(8'h3C, 4'd4);

    // R7: divisor 1
    for (int k = 0; k < 16; k++) begin
      apply(8'(k), 4'd1);
      check("R7 quotient", int'(quotient), k);
      check("R7 remainder", int'(remainder), 0);
    end

    // R8: dividend below divisor
    for (int k = 1; k < 16; k++) begin
      apply(8'(k - 1), 4'(k));
      check("R8 quotient", int'(quotient), 0);
      check("R8 remainder", int'(remainder), k - 1);
    end

    // R9: remember one result, stir, re-apply
    apply(8'd201, 4'd13);
    q_first = quotient;
    r_first = remainder;
    check("R1 201/13", int'(quotient), 15);
    check("R2 201%13", int'(remainder), 6);

    // Random with a bias toward non-overflow operands
    for (int n = 0; n < 600; n++) begin
      logic [3:0] b;
      logic [7:0] a;
      b = 4'($urandom_range(0, 15));
      a = 8'($urandom_range(0, 255));
      if (n % 3 != 0 && b != 4'd0) a = 8'($urandom_range(0, 16 * int'(b) - 1));
      full_check(a, b);
    end

    apply(8'd201, 4'd13);
    check("R9 repeat quotient", int'(quotient), int'(q_first));
    check("R9 repeat remainder", int'(remainder), int'(r_first));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule